// File: doc/BRIEF.md
# Transition-Counting Random Bit Sampler with Health Window

This block drives and harvests a damped-oscillation entropy source. Once per sampling interval it flips an excitation line. Each flip upsets a ring that is otherwise stable, and the ring rings down. While the ring rings down, the block counts every level change on the returning oscillator line. The parity of that count is the raw random bit.

Each count is also a health measurement. A count inside a programmable `[lo, hi]` window releases the bit with a one-cycle strobe. A count outside the window is dropped. It produces a one-cycle reject pulse and sets a sticky alarm, which is useful for detecting tampered or drifting operating conditions. The output is raw and biased, and it is meant to feed a separate whitening stage.

The interval length is a register in system clocks. After reset the excitation line sits low for one full interval before its first flip. The oscillator line is asynchronous and is synchronized inside the block.

Top module: `trng_sampler`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `excite`, `bit_valid`, `reject_pulse` and `alarm` are all 0.
- R2: After reset is released, `excite` first inverts exactly N clocks later, where N is the effective interval length. After that it inverts every N clocks. Each inversion ends one counting window and starts the next.
- R3: A `settle_len` of 0 behaves as an interval of 1 clock.
- R4: The count covers both rising and falling transitions of `osc_in` that occur inside a window. `rand_bit` equals bit 0 of that count.
- R5: `bit_valid` is high for exactly the cycle in which a window's result is presented. That cycle coincides with an `excite` inversion. It is high only when `thr_lo <= count <= thr_hi` and the count is not saturated.
- R6: A count outside the window sets `reject_pulse` high for that result cycle, and `bit_valid` stays low.
- R7: The 8-bit count saturates at 255. A saturated count is always rejected, even when `thr_hi` is 255.
- R8: `alarm` rises together with any `reject_pulse` and stays high until a clock in which `alarm_clr` is 1. If a reject happens in the same clock as a clear, the set wins.
- R9: The count restarts from zero in every window, so transitions from one window never add to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| settle_len | input | SETTLE_W | Interval length in clocks (0 is treated as 1) |
| thr_lo | input | 8 | Lowest acceptable count |
| thr_hi | input | 8 | Highest acceptable count |
| alarm_clr | input | 1 | Clear request for the sticky alarm |
| osc_in | input | 1 | Asynchronous oscillator return line |
| excite | output | 1 | Excitation control line, inverted once per interval |
| bit_valid | output | 1 | Strobe marking an accepted bit |
| rand_bit | output | 1 | Parity of the last window's count |
| reject_pulse | output | 1 | One-cycle mark of a rejected count |
| alarm | output | 1 | Sticky health alarm |

## Verification
The assertions check on every clock the relations between the outputs:
- the reset state;
- that an accepted strobe never coincides with a reject;
- that every result lands on an excitation inversion;
- that the alarm rises only with a reject and falls only after a clear.

Other behaviour can only be shown by the bench scenarios, which drive known numbers of oscillator transitions into each window. These scenarios cover the interval timing, including the zero-length case, the parity of the count, the window bounds at both ends, saturation, and the per-window restart. A behavioural model predicts the excitation level, strobe, bit, reject and alarm for every clock.

// File: rtl/trng_pkg.sv
package trng_pkg;

    localparam int CNT_W = 8;

    typedef enum logic {
        PH_WARMUP = 1'b0,
        PH_COUNT  = 1'b1
    } phase_t;

    typedef struct packed {
        logic accept;
        logic reject;
        logic parity;
    } verdict_t;

    function automatic verdict_t judge_count(
        input logic [CNT_W-1:0] cnt,
        input logic [CNT_W-1:0] lo,
        input logic [CNT_W-1:0] hi
    );
        verdict_t v;
        logic in_win;
        in_win   = (cnt != {CNT_W{1'b1}}) && (cnt >= lo) && (cnt <= hi);
        v.accept = in_win;
        v.reject = !in_win;
        v.parity = cnt[0];
        return v;
    endfunction

endpackage

// File: rtl/trng_sync_edge.sv
module trng_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic any_edge
);
    logic [STAGES-1:0] chain;
    logic              last_lvl;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_lvl <= 1'b0;
        else     last_lvl <= chain[STAGES-1];
    end

    assign any_edge = chain[STAGES-1] ^ last_lvl;
endmodule

// File: rtl/trng_interval_timer.sv
module trng_interval_timer #(
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic                tick
);
    logic [SETTLE_W-1:0] elapsed;
    logic [SETTLE_W-1:0] eff_len;

    assign eff_len = (settle_len == '0) ? SETTLE_W'(1) : settle_len;
    assign tick    = (elapsed >= eff_len - SETTLE_W'(1));

    always_ff @(posedge clk) begin
        if (rst || tick) elapsed <= '0;
        else             elapsed <= elapsed + SETTLE_W'(1);
    end
endmodule

// File: rtl/trng_edge_counter.sv
module trng_edge_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear)               count <= '0;
        else if (inc && count != '1)    count <= count + W'(1);
    end
endmodule

// File: rtl/trng_sampler.sv
module trng_sampler
    import trng_pkg::*;
#(
    parameter int SETTLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic [CNT_W-1:0]    thr_lo,
    input  logic [CNT_W-1:0]    thr_hi,
    input  logic                alarm_clr,
    input  logic                osc_in,
    output logic                excite,
    output logic                bit_valid,
    output logic                rand_bit,
    output logic                reject_pulse,
    output logic                alarm
);
    logic             osc_edge;
    logic             tick;
    logic [CNT_W-1:0] count;
    phase_t           phase;
    verdict_t         verdict;
    logic             result_now;

    trng_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .async_in(osc_in), .any_edge(osc_edge)
    );

    trng_interval_timer #(.SETTLE_W(SETTLE_W)) i_timer (
        .clk(clk), .rst(rst), .settle_len(settle_len), .tick(tick)
    );

    trng_edge_counter #(.W(CNT_W)) i_count (
        .clk(clk), .rst(rst), .clear(tick),
        .inc(osc_edge && (phase == PH_COUNT)), .count(count)
    );

    assign verdict    = judge_count(count, thr_lo, thr_hi);
    assign result_now = tick && (phase == PH_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_WARMUP;
            excite       <= 1'b0;
            bit_valid    <= 1'b0;
            rand_bit     <= 1'b0;
            reject_pulse <= 1'b0;
            alarm        <= 1'b0;
        end else begin
            if (tick) begin
                phase  <= PH_COUNT;
                excite <= ~excite;
            end
            bit_valid    <= result_now && verdict.accept;
            reject_pulse <= result_now && verdict.reject;
            if (result_now) rand_bit <= verdict.parity;
            if (result_now && verdict.reject) alarm <= 1'b1;
            else if (alarm_clr)               alarm <= 1'b0;
        end
    end
endmodule

// File: rtl/trng_sampler_checker.sv
module trng_sampler_checker (
    input logic clk,
    input logic rst,
    input logic alarm_clr,
    input logic excite,
    input logic bit_valid,
    input logic reject_pulse,
    input logic alarm
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!excite && !bit_valid && !reject_pulse && !alarm));

    assert_accept_not_reject_R5: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && reject_pulse));

    assert_result_on_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_valid || reject_pulse) |-> (excite != $past(excite)));

    assert_reject_sets_alarm_R6: assert property (@(posedge clk) disable iff (rst)
        reject_pulse |-> alarm);

    assert_alarm_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> reject_pulse);

    assert_alarm_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm) |-> $past(alarm_clr));
endmodule

bind trng_sampler trng_sampler_checker i_checker (
    .clk(clk), .rst(rst), .alarm_clr(alarm_clr), .excite(excite),
    .bit_valid(bit_valid), .reject_pulse(reject_pulse), .alarm(alarm)
);

// File: tb/test_trng_sampler.sv
`timescale 1ns/1ps
module test_trng_sampler;
    localparam int SETTLE_W = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [SETTLE_W-1:0] settle_len = 16'd64;
    logic [7:0]          thr_lo = 8'd2;
    logic [7:0]          thr_hi = 8'd20;
    logic                alarm_clr = 1'b0;
    logic                osc_in = 1'b0;
    logic                excite, bit_valid, rand_bit, reject_pulse, alarm;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    trng_sampler #(.SETTLE_W(SETTLE_W)) i_trng_sampler (
        .clk(clk), .rst(rst), .settle_len(settle_len), .thr_lo(thr_lo),
        .thr_hi(thr_hi), .alarm_clr(alarm_clr), .osc_in(osc_in),
        .excite(excite), .bit_valid(bit_valid), .rand_bit(rand_bit),
        .reject_pulse(reject_pulse), .alarm(alarm)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model
    int   q_counts[$];
    int   since;
    bit   first_flip;
    bit   lvl_m;
    bit   alarm_m;
    bit   bit_m;

    always @(posedge clk) begin
        #2;
        if (rst) begin
            since = 0; first_flip = 1; lvl_m = 0; alarm_m = 0; bit_m = 0;
            q_counts.delete();
            check("R1 excite", excite, 0);
            check("R1 valid", bit_valid, 0);
            check("R1 reject", reject_pulse, 0);
            check("R1 alarm", alarm, 0);
        end else begin
            int  eff;
            bit  flip, v_m, r_m;
            eff  = (settle_len == 0) ? 1 : int'(settle_len);
            since++;
            flip = (since == eff);
            v_m = 0; r_m = 0;
            if (flip) begin
                since = 0;
                lvl_m = !lvl_m;
                if (first_flip) first_flip = 0;
                else begin
                    int n, c;
                    string tag;
                    n = (q_counts.size() > 0) ? q_counts.pop_front() : 0;
                    c = (n > 255) ? 255 : n;   // R7 saturation; R9 fresh count per window
                    v_m = (c != 255) && (c >= thr_lo) && (c <= thr_hi);
                    r_m = !v_m;
                    bit_m = c[0];
                    tag = (c == 255) ? "R7 saturated reject" : "R4 parity";
                    check(tag, reject_pulse, r_m);
                    check("R4 rand_bit", rand_bit, bit_m);
                end
            end
            alarm_m = r_m ? 1'b1 : (alarm_clr ? 1'b0 : alarm_m);
            check((settle_len == 0) ? "R3 excite" : "R2 excite", excite, lvl_m);
            check("R5 bit_valid", bit_valid, v_m);
            check("R6 reject_pulse", reject_pulse, r_m);
            check("R8 alarm", alarm, alarm_m);
        end
    end

    task automatic run_window(input int n);
        @(excite);
        q_counts.push_back(n);
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            osc_in = ~osc_in;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic close_scenario();
        @(excite);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // Scenario A: window [2,20], interval 64 (R2 R4 R5 R6 R8 R9)
        settle_len = 16'd64; thr_lo = 8'd2; thr_hi = 8'd20;
        rst = 1'b0;
        run_window(5);
        run_window(6);
        run_window(0);    // below lo -> reject, alarm (R6)
        run_window(3);    // count restarts (R9); alarm stays (R8)
        run_window(25);   // above hi -> reject
        @(excite);
        q_counts.push_back(2);     // lower bound accepted (R5)
        repeat (2) @(negedge clk);
        alarm_clr = 1'b1;
        @(negedge clk);
        alarm_clr = 1'b0;
        repeat (1) @(negedge clk);
        osc_in = ~osc_in; repeat (2) @(negedge clk);
        osc_in = ~osc_in; repeat (2) @(negedge clk);
        run_window(20);   // upper bound accepted
        run_window(21);   // just above -> reject
        run_window(7);
        close_scenario();

        // Scenario B: saturation with full window (R7)
        settle_len = 16'd600; thr_lo = 8'd0; thr_hi = 8'd255;
        rst = 1'b0;
        run_window(254);
        run_window(260);
        run_window(255);
        run_window(1);
        close_scenario();

        // Scenario C: zero interval behaves as one clock (R3)
        settle_len = 16'd0; thr_lo = 8'd0; thr_hi = 8'd255;
        rst = 1'b0;
        repeat (12) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule